// File: doc/BRIEF.md
# MMC Command Token Transmitter

This block sends one command token on the MMC/eMMC command line. A start pulse with a 6-bit command index and a 32-bit argument is accepted when the block is idle. The block then shifts out a 48-bit token, most significant bit first, with the bit value changing just after each falling edge of the card clock. The token is a start bit of 0, a direction bit of 1, the index, the argument, a 7-bit checksum and a closing 1. The checksum is computed bit by bit while the first 40 bits go out, so no precomputed table is needed and a wrong checksum can never reach the card.

One card-clock period after the closing bit, the block stops driving the line so that the card can answer. It raises a one-cycle completion pulse at that moment. The block also makes the slow identification clock for the card by dividing the system clock. The default divide of 32 gives about 375 kHz from a 12 MHz system clock. The tri-state pad is left outside the block and driven by a data output and a drive-enable output. The line is pulled high on the board, so it reads as 1 whenever it is released.

Top module: `mmc_cmd_tx`

## Requirements
- R1: A token is 48 bits sent MSB first. Line bit 47 is 0, bit 46 is 1, bits 45..40 are the command index, bits 39..8 are the argument, bits 7..1 are the checksum and bit 0 is 1.
- R2: The checksum is the remainder of the first 40 token bits times x^7, divided by x^7+x^3+1, with the register starting from zero for every token. Index 0 with argument 0 gives 1001010. Index 1 with argument 0x80FF8080 gives 0010110. Index 1 with argument 0xC0FF8080 gives 1011111.
- R3: `cmd_o` changes only while `card_clk` is low, one system cycle after a card-clock falling edge. Each token bit is therefore stable at the card-clock rising edge where it is sampled.
- R4: `cmd_oe` is high from the first token bit until one card-clock period after the closing bit. It then drops at a card-clock falling edge, with `cmd_o` left at 1.
- R5: `done` is a single-cycle pulse in the same cycle that `cmd_oe` drops.
- R6: `busy` rises in the cycle after an accepted `start` and stays high until the cycle in which `done` pulses.
- R7: A `start` while `busy` is high is ignored. The token in progress is unchanged and no second token follows.
- R8: `card_clk` runs at the system clock divided by CLK_DIV (default 32) with a 50% duty cycle.
- R9: After reset, `cmd_oe`, `busy`, `done` and `card_clk` are 0 and `cmd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send one token |
| cmd_index | input | 6 | Command index, sampled with an accepted start |
| cmd_arg | input | 32 | Command argument, sampled with an accepted start |
| busy | output | 1 | A token is being sent |
| done | output | 1 | One-cycle pulse when the line is released |
| card_clk | output | 1 | Divided identification clock to the card |
| cmd_o | output | 1 | Command line data value |
| cmd_oe | output | 1 | Command line drive enable (0 leaves the pad at high impedance) |

## Verification
The hardest case to reach is a start request that arrives in the middle of a token. It must leave both the token on the line and the following idle period untouched. The bench raises a request with a different index and argument ten card-clock periods into a token. It then checks that the captured token is still the original one, and that the line stays released and the block idle for several card periods afterwards. A sweep over all 64 command indexes, each with its own argument, checks the whole token against a checksum that the bench computes by polynomial division. The three fixed identification-command checksums are also checked on their own.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  // Transmitter sequencing states
  typedef enum logic [0:0] {
    TX_IDLE = 1'b0,
    TX_RUN  = 1'b1
  } tx_state_e;

  // Generator polynomial x^7 + x^3 + 1 without the x^7 term
  localparam logic [6:0] CRC7_POLY = 7'h09;
endpackage

// File: rtl/mmc_clk_div.sv
module mmc_clk_div #(
  parameter int CLK_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  output logic card_clk,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      card_clk <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      if (cnt_q == CW'(CLK_DIV - 1)) begin
        cnt_q    <= '0;
        card_clk <= 1'b0;
        fall_stb <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(HALF - 1)) begin
          card_clk <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmc_crc7_ser.sv
module mmc_crc7_ser #(
  parameter int         CRC_W = 7,
  parameter logic [6:0] POLY  = mmc_cmd_pkg::CRC7_POLY
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic calc_en,
  input  logic shift_en,
  input  logic bit_in,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb    = bit_in ^ crc_q[CRC_W-1];
  assign msb_o = crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '0;
    end else if (calc_en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end else if (shift_en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mmc_frame_shift.sv
module mmc_frame_shift
  import mmc_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CRC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             fall_stb,
  input  logic             crc_msb,
  output logic             crc_clr,
  output logic             crc_calc,
  output logic             crc_shift,
  output logic             crc_bit,
  output logic             busy,
  output logic             done,
  output logic             cmd_o,
  output logic             cmd_oe
);
  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_state_e        state_q;
  logic [HDR_W-1:0] hdr_q;
  logic [CNT_W-1:0] bit_q;
  logic             accept;
  logic             in_hdr;
  logic             in_crc;

  assign accept    = (state_q == TX_IDLE) && start;
  assign in_hdr    = bit_q < CNT_W'(HDR_W);
  assign in_crc    = !in_hdr && (bit_q < CNT_W'(HDR_W + CRC_W));
  assign crc_clr   = accept;
  assign crc_bit   = hdr_q[HDR_W-1];
  assign crc_calc  = (state_q == TX_RUN) && fall_stb && in_hdr;
  assign crc_shift = (state_q == TX_RUN) && fall_stb && in_crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      hdr_q   <= '0;
      bit_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cmd_o   <= 1'b1;
      cmd_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        TX_IDLE: begin
          if (accept) begin
            hdr_q   <= {2'b01, cmd_index, cmd_arg};
            bit_q   <= '0;
            busy    <= 1'b1;
            state_q <= TX_RUN;
          end
        end
        TX_RUN: begin
          if (fall_stb) begin
            bit_q <= bit_q + 1'b1;
            if (in_hdr) begin
              cmd_o  <= hdr_q[HDR_W-1];
              cmd_oe <= 1'b1;
              hdr_q  <= {hdr_q[HDR_W-2:0], 1'b0};
            end else if (in_crc) begin
              cmd_o <= crc_msb;
            end else if (bit_q == CNT_W'(FRAME_W - 1)) begin
              cmd_o <= 1'b1;
            end else begin
              cmd_o   <= 1'b1;
              cmd_oe  <= 1'b0;
              busy    <= 1'b0;
              done    <= 1'b1;
              state_q <= TX_IDLE;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmc_cmd_tx.sv
module mmc_cmd_tx #(
  parameter int CLK_DIV = 32,
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int CRC_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             busy,
  output logic             done,
  output logic             card_clk,
  output logic             cmd_o,
  output logic             cmd_oe
);
  logic fall_stb;
  logic crc_clr, crc_calc, crc_shift, crc_bit, crc_msb;

  mmc_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .card_clk (card_clk),
    .fall_stb (fall_stb)
  );

  mmc_crc7_ser #(.CRC_W(CRC_W)) u_crc (
    .clk      (clk),
    .rst      (rst),
    .clr      (crc_clr),
    .calc_en  (crc_calc),
    .shift_en (crc_shift),
    .bit_in   (crc_bit),
    .msb_o    (crc_msb)
  );

  mmc_frame_shift #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_index (cmd_index),
    .cmd_arg   (cmd_arg),
    .fall_stb  (fall_stb),
    .crc_msb   (crc_msb),
    .crc_clr   (crc_clr),
    .crc_calc  (crc_calc),
    .crc_shift (crc_shift),
    .crc_bit   (crc_bit),
    .busy      (busy),
    .done      (done),
    .cmd_o     (cmd_o),
    .cmd_oe    (cmd_oe)
  );
endmodule

// File: rtl/mmc_cmd_tx_chk.sv
module mmc_cmd_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic card_clk,
  input logic cmd_o,
  input logic cmd_oe
);
  p_cmd_on_low_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != $past(cmd_o)) |-> !card_clk);

  p_oe_fall_low_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> (!card_clk && cmd_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_release_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cmd_oe && $past(cmd_oe)));

  p_oe_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

bind mmc_cmd_tx mmc_cmd_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .card_clk (card_clk),
  .cmd_o    (cmd_o),
  .cmd_oe   (cmd_oe)
);

// File: tb/sim_mmc_cmd_tx.sv
module sim_mmc_cmd_tx;
  localparam int PERIOD = 10;
  localparam int DIV    = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        busy, done, card_clk, cmd_o, cmd_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mmc_cmd_tx #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .busy(busy), .done(done), .card_clk(card_clk),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Remainder of msg*x^7 modulo x^7+x^3+1 by long division
  function automatic logic [6:0] ref_crc(input logic [39:0] msg);
    logic [46:0] m;
    m = {msg, 7'b0};
    for (int i = 46; i >= 7; i--) begin
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    end
    return m[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_index = idx;
    cmd_arg   = arg;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
  endtask

  task automatic capture(output logic [47:0] got);
    while (!cmd_oe) @(negedge clk);
    for (int i = 47; i >= 0; i--) begin
      @(posedge card_clk);
      #1;
      got[i] = cmd_o;
      if (!cmd_oe) chk(1'b0, "R4 oe during token", 0, 1);
    end
  endtask

  task automatic finish_frame(input string tag);
    int n;
    n = 0;
    while (!done && n < 2*DIV) begin
      @(negedge clk);
      n++;
    end
    chk(done && !cmd_oe && !busy && cmd_o, {tag, " R4 R5 release"},
        {done, cmd_oe, busy, cmd_o}, 4'b1001);
    chk(n <= DIV, {tag, " R4 release delay"}, n, DIV);
    @(negedge clk);
    chk(!done, {tag, " R5 done one cycle"}, done, 0);
  endtask

  task automatic send_check(input logic [5:0] idx, input logic [31:0] arg, input string tag);
    logic [47:0] got;
    issue(idx, arg);
    capture(got);
    chk(got == ref_frame(idx, arg), {tag, " R1 R2 R3 token"}, got, ref_frame(idx, arg));
    finish_frame(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] got;
    int hi, rises, first_rise, second_rise;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!cmd_oe && !busy && !done && cmd_o, "R9 reset outputs",
        {cmd_oe, busy, done, cmd_o}, 4'b0001);
    chk(!card_clk, "R9 card_clk low", card_clk, 0);

    // R8 divided clock, 50% duty
    hi = 0; rises = 0; first_rise = 0; second_rise = 0; prev = card_clk;
    for (int c = 0; c < 4*DIV; c++) begin
      @(negedge clk);
      if (card_clk) hi++;
      if (card_clk && !prev) begin
        rises++;
        if (rises == 1) first_rise = c;
        if (rises == 2) second_rise = c;
      end
      prev = card_clk;
    end
    chk(hi == 2*DIV, "R8 duty", hi, 2*DIV);
    chk(rises == 4, "R8 rise count", rises, 4);
    chk(second_rise - first_rise == DIV, "R8 period", second_rise - first_rise, DIV);

    // R2 fixed identification checksums
    chk(ref_frame(6'd0, 32'h0)[7:1] == 7'b1001010, "R2 ref idx0", ref_frame(6'd0, 32'h0)[7:1], 7'b1001010);
    issue(6'd0, 32'h0);
    capture(got);
    chk(got[7:1] == 7'b1001010, "R2 crc idx0", got[7:1], 7'b1001010);
    chk(got == {2'b01, 6'd0, 32'h0, 7'b1001010, 1'b1}, "R1 token idx0", got,
        {2'b01, 6'd0, 32'h0, 7'b1001010, 1'b1});
    finish_frame("idx0");

    issue(6'd1, 32'h80FF8080);
    capture(got);
    chk(got[7:1] == 7'b0010110, "R2 crc 80FF8080", got[7:1], 7'b0010110);
    finish_frame("op80");

    // R7 start while busy ignored
    fork
      begin
        issue(6'd1, 32'hC0FF8080);
        capture(got);
      end
      begin
        while (!cmd_oe) @(negedge clk);
        repeat (10*DIV) @(negedge clk);
        cmd_index = 6'd5;
        cmd_arg   = 32'h0;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
      end
    join
    chk(got[7:1] == 7'b1011111, "R2 crc C0FF8080", got[7:1], 7'b1011111);
    chk(got == ref_frame(6'd1, 32'hC0FF8080), "R7 token unchanged", got, ref_frame(6'd1, 32'hC0FF8080));
    finish_frame("opC0");
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 4*DIV; c++) begin
        @(negedge clk);
        if (cmd_oe || busy) seen++;
      end
      chk(seen == 0, "R7 no second token", seen, 0);
    end

    // Sweep all indexes, varied arguments
    for (int i = 0; i < 64; i++) begin
      send_check(6'(i), (32'h9E3779B1 * (i + 1)) ^ {i[7:0], 24'h5A0F3C}, "sweep");
    end

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule